// File: doc/BRIEF.md
# Binarized Popcount Vote Classifier

This block makes a yes/no decision over 40 signed 8-bit feature channels. Each channel is compared with a signed 8-bit threshold of its own, and the result is one vote bit per channel. Channels 0 to 19 vote for detection and channels 20 to 39 vote against it. Two small popcounts count the votes in each group. The block subtracts the against-count from the for-count and compares the signed margin with an integer decision constant. Per-channel binarization and two small counts take the place of a wide signed adder tree, so only a few narrow carry chains remain.

The thresholds can arrive on a runtime bus. They can also be fixed at build time through a parameter, so synthesis can fold the comparators into constants. A parameter decides whether the detect bit leaves combinationally or through one register stage. Both group counts and the signed margin are brought out as debug ports, so each stage of the datapath can be checked on its own.

Top module: `vote_classifier`

## Requirements
- R1: The features and the thresholds are each packed into a 320-bit bus, with channel i held in bits [8i+7:8i] as a two's-complement byte.
- R2: The vote of channel i is 1 only when its feature is strictly greater than its threshold under signed comparison. A feature equal to its threshold gives a 0 vote.
- R3: `pos_cnt_o` is a 5-bit count of the 1 votes among channels 0 to 19.
- R4: `neg_cnt_o` is a 5-bit count of the 1 votes among channels 20 to 39.
- R5: `score_o` is the 6-bit two's-complement value `pos_cnt_o - neg_cnt_o`. It always lies in the range -20 to +20.
- R6: The detect decision is 1 only when the score is strictly greater than the parameter `K`. `K` is a signed integer in [-20, 20] with a default of 13. A score equal to `K` gives 0.
- R7: With `REG_OUT` = 0, `detect_o` follows the inputs combinationally, in the same cycle.
- R8: With `REG_OUT` = 1, `detect_o` takes the decision on the rising clock edge and holds it for one cycle.
- R9: With `REG_OUT` = 1, a synchronous active-high `rst` clears `detect_o` to 0 on the next rising edge.
- R10: With `FIXED_THR` = 1, the thresholds come from the parameter `THR_CONST`, which uses the packing of R1. The `thr_i` input then has no effect on any output.
- R11: `pos_cnt_o`, `neg_cnt_o` and `score_o` are combinational in both output modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| feat_i | input | 320 | Packed signed feature bytes, channel i at [8i+7:8i] |
| thr_i | input | 320 | Packed signed runtime thresholds, same packing |
| detect_o | output | 1 | Detect decision |
| pos_cnt_o | output | 5 | Vote count of channels 0 to 19 |
| neg_cnt_o | output | 5 | Vote count of channels 20 to 39 |
| score_o | output | 6 | Signed margin, positive count minus negative count |

## Verification
On every cycle the assertions check the following:
- the count bounds and the score range;
- that a threshold bus equal to the feature bus gives empty counts;
- that the detect bit tracks the margin either at once or one edge later, depending on the mode;
- that reset clears the registered bit.

Only the bench scenarios can show the rest:
- that each vote lands in the right group;
- that ties on both the channel and the decision constant resolve to 0;
- the extremes of +20 and -20;
- that the folded thresholds really ignore the runtime bus.

The bench shows these by comparing against reference functions, using two instances with different constants and output modes.

// File: rtl/vote_pkg.sv
package vote_pkg;

    localparam int FEAT_W   = 8;
    localparam int NUM_CH   = 40;
    localparam int GROUP    = NUM_CH / 2;
    localparam int CNT_W    = $clog2(GROUP + 1);
    localparam int SCORE_W  = CNT_W + 1;
    localparam int BUS_W    = NUM_CH * FEAT_W;

    typedef logic signed [FEAT_W-1:0]  feat_t;
    typedef logic        [CNT_W-1:0]   cnt_t;
    typedef logic signed [SCORE_W-1:0] score_t;
    typedef logic        [NUM_CH-1:0]  votes_t;

    typedef struct packed {
        cnt_t pos;
        cnt_t neg;
    } tally_t;

    // Signed margin of the two group counts, widened by one sign bit.
    function automatic score_t margin(input tally_t t);
        return $signed({1'b0, t.pos}) - $signed({1'b0, t.neg});
    endfunction

endpackage

// File: rtl/vote_bank.sv
module vote_bank
    import vote_pkg::*;
#(
    parameter int N_CH = NUM_CH,
    parameter int W    = FEAT_W
) (
    input  logic [N_CH*W-1:0] feat,
    input  logic [N_CH*W-1:0] thr,
    output logic [N_CH-1:0]   votes
);
    for (genvar c = 0; c < N_CH; c++) begin : g_cmp
        logic signed [W-1:0] f_s;
        logic signed [W-1:0] t_s;
        assign f_s      = feat[c*W +: W];
        assign t_s      = thr[c*W +: W];
        assign votes[c] = (f_s > t_s);
    end
endmodule

// File: rtl/vote_popcount.sv
module vote_popcount #(
    parameter int N  = 20,
    parameter int CW = $clog2(N + 1)
) (
    input  logic [N-1:0]  bits,
    output logic [CW-1:0] count
);
    always_comb begin
        count = '0;
        for (int b = 0; b < N; b++) begin
            count = count + CW'(bits[b]);
        end
    end
endmodule

// File: rtl/vote_decide.sv
module vote_decide
    import vote_pkg::*;
#(
    parameter int K       = 13,
    parameter bit REG_OUT = 1'b1
) (
    input  logic   clk,
    input  logic   rst,
    input  tally_t tally,
    output score_t score,
    output logic   detect
);
    localparam score_t K_S = score_t'(K);

    logic det_c;
    logic det_q;

    always_comb begin
        score = margin(tally);
        det_c = (score > K_S);
    end

    always_ff @(posedge clk) begin
        if (rst) det_q <= 1'b0;
        else     det_q <= det_c;
    end

    assign detect = REG_OUT ? det_q : det_c;
endmodule

// File: rtl/vote_classifier.sv
module vote_classifier
    import vote_pkg::*;
#(
    parameter int                 K         = 13,
    parameter bit                 FIXED_THR = 1'b0,
    parameter bit                 REG_OUT   = 1'b1,
    parameter logic [BUS_W-1:0]   THR_CONST = '0
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [BUS_W-1:0]          feat_i,
    input  logic [BUS_W-1:0]          thr_i,
    output logic                      detect_o,
    output logic [CNT_W-1:0]          pos_cnt_o,
    output logic [CNT_W-1:0]          neg_cnt_o,
    output logic signed [SCORE_W-1:0] score_o
);
    logic [BUS_W-1:0] thr_sel;
    votes_t           votes;
    tally_t           tally;

    // Constant thresholds let synthesis fold each comparator.
    assign thr_sel = FIXED_THR ? THR_CONST : thr_i;

    vote_bank #(.N_CH(NUM_CH), .W(FEAT_W)) bank_i (
        .feat  (feat_i),
        .thr   (thr_sel),
        .votes (votes)
    );

    vote_popcount #(.N(GROUP), .CW(CNT_W)) pos_cnt_i (
        .bits  (votes[GROUP-1:0]),
        .count (tally.pos)
    );

    vote_popcount #(.N(GROUP), .CW(CNT_W)) neg_cnt_i (
        .bits  (votes[NUM_CH-1:GROUP]),
        .count (tally.neg)
    );

    vote_decide #(.K(K), .REG_OUT(REG_OUT)) decide_i (
        .clk    (clk),
        .rst    (rst),
        .tally  (tally),
        .score  (score_o),
        .detect (detect_o)
    );

    assign pos_cnt_o = tally.pos;
    assign neg_cnt_o = tally.neg;
endmodule

// File: rtl/vote_classifier_chk.sv
module vote_classifier_chk
    import vote_pkg::*;
#(
    parameter int K         = 13,
    parameter bit FIXED_THR = 1'b0,
    parameter bit REG_OUT   = 1'b1
) (
    input logic                      clk,
    input logic                      rst,
    input logic [BUS_W-1:0]          feat_i,
    input logic [BUS_W-1:0]          thr_i,
    input logic                      detect_o,
    input logic [CNT_W-1:0]          pos_cnt_o,
    input logic [CNT_W-1:0]          neg_cnt_o,
    input logic signed [SCORE_W-1:0] score_o
);
    localparam logic signed [SCORE_W-1:0] K_S  = SCORE_W'(K);
    localparam logic signed [SCORE_W-1:0] LIM  = SCORE_W'(GROUP);
    localparam logic        [CNT_W-1:0]   CMAX = CNT_W'(GROUP);

    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
        (pos_cnt_o <= CMAX) && (neg_cnt_o <= CMAX));

    p_score_range_r5: assert property (@(posedge clk) disable iff (rst)
        (score_o >= -LIM) && (score_o <= LIM));

    if (!FIXED_THR) begin : g_tie
        p_tie_empty_r2: assert property (@(posedge clk) disable iff (rst)
            (feat_i == thr_i) |-> (pos_cnt_o == '0) && (neg_cnt_o == '0));
    end

    if (REG_OUT) begin : g_reg
        p_reg_delay_r8: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> (detect_o == $past(score_o > K_S)));
        p_reset_clear_r9: assert property (@(posedge clk)
            rst |=> !detect_o);
    end else begin : g_comb
        p_comb_follow_r7: assert property (@(posedge clk) disable iff (rst)
            detect_o == (score_o > K_S));
    end
endmodule

bind vote_classifier vote_classifier_chk #(
    .K(K), .FIXED_THR(FIXED_THR), .REG_OUT(REG_OUT)
) chk_i (
    .clk(clk), .rst(rst), .feat_i(feat_i), .thr_i(thr_i),
    .detect_o(detect_o), .pos_cnt_o(pos_cnt_o),
    .neg_cnt_o(neg_cnt_o), .score_o(score_o)
);

// File: tb/vote_classifier_tb_top.sv
module vote_classifier_tb_top;

    localparam int FIX_K = -3;

    function automatic logic [319:0] build_fix_thr();
        logic [319:0] v;
        for (int i = 0; i < 40; i++) v[8*i +: 8] = 8'((i * 13) % 200 - 100);
        return v;
    endfunction

    localparam logic [319:0] FIX_THR = build_fix_thr();

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [319:0] feat = '0;
    logic [319:0] thr  = '0;

    logic              det_a, det_b;
    logic [4:0]        pos_a, neg_a, pos_b, neg_b;
    logic signed [5:0] sc_a, sc_b;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    vote_classifier #(.K(13), .FIXED_THR(1'b0), .REG_OUT(1'b0)) dut_i (
        .clk(clk), .rst(rst), .feat_i(feat), .thr_i(thr),
        .detect_o(det_a), .pos_cnt_o(pos_a), .neg_cnt_o(neg_a), .score_o(sc_a)
    );

    vote_classifier #(.K(FIX_K), .FIXED_THR(1'b1), .REG_OUT(1'b1),
                      .THR_CONST(FIX_THR)) dut_fix_i (
        .clk(clk), .rst(rst), .feat_i(feat), .thr_i(thr),
        .detect_o(det_b), .pos_cnt_o(pos_b), .neg_cnt_o(neg_b), .score_o(sc_b)
    );

    // Reference: R1 packing, R2 strict signed vote.
    function automatic logic [39:0] ref_votes(logic [319:0] f, logic [319:0] t);
        logic [39:0] v;
        for (int i = 0; i < 40; i++)
            v[i] = $signed(f[8*i +: 8]) > $signed(t[8*i +: 8]);
        return v;
    endfunction

    function automatic logic [319:0] build_feat(int np, int nn, logic [319:0] t);
        logic [319:0] f;
        for (int i = 0; i < 20; i++)
            f[8*i +: 8] = t[8*i +: 8] + ((i < np) ? 8'd1 : 8'd0);
        for (int i = 20; i < 40; i++)
            f[8*i +: 8] = t[8*i +: 8] + ((i - 20 < nn) ? 8'd1 : 8'd0);
        return f;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive at negedge, check combinational outputs, then the registered bit.
    task automatic apply(logic [319:0] f, logic [319:0] t);
        logic [39:0] va, vb;
        int pa, na, pb, nb;
        @(negedge clk);
        feat = f;
        thr  = t;
        va = ref_votes(f, t);
        vb = ref_votes(f, FIX_THR);
        pa = $countones(va[19:0]);  na = $countones(va[39:20]);
        pb = $countones(vb[19:0]);  nb = $countones(vb[39:20]);
        #2;
        chk("R3 pos count", int'(pos_a), pa);
        chk("R4 neg count", int'(neg_a), na);
        chk("R5 score", int'(sc_a), pa - na);
        chk("R6/R7 comb detect", int'(det_a), int'((pa - na) > 13));
        chk("R10/R11 fixed pos", int'(pos_b), pb);
        chk("R10/R11 fixed neg", int'(neg_b), nb);
        chk("R10/R11 fixed score", int'(sc_b), pb - nb);
        @(negedge clk);
        chk("R8 reg detect", int'(det_b), int'((pb - nb) > FIX_K));
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual 0 expected 1 (run ended)");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0b17));
        repeat (2) @(negedge clk);
        chk("R9 reset detect", int'(det_b), 0);
        rst = 1'b0;

        // Directed corner cases.
        apply(build_feat(0, 0, FIX_THR), FIX_THR);     // R2 ties give no votes
        apply(build_feat(20, 0, FIX_THR), FIX_THR);    // +20
        apply(build_feat(0, 20, FIX_THR), FIX_THR);    // -20
        apply(build_feat(13, 0, FIX_THR), FIX_THR);    // R6 score == K
        apply(build_feat(14, 0, FIX_THR), FIX_THR);
        apply(build_feat(17, 4, FIX_THR), FIX_THR);
        apply(build_feat(0, 3, FIX_THR), FIX_THR);     // fixed score == K
        apply(build_feat(0, 2, FIX_THR), FIX_THR);

        // R1: a single vote in channel 25 must land in the negative group.
        begin
            logic [319:0] f1;
            f1 = FIX_THR;
            f1[8*25 +: 8] = FIX_THR[8*25 +: 8] + 8'd1;
            @(negedge clk);
            feat = f1; thr = FIX_THR;
            #2;
            chk("R1 channel 25 placement", int'(neg_a), 1);
            chk("R1 channel 25 placement pos", int'(pos_a), 0);
        end

        // R2 signed extremes: -128 vs 127 and 127 vs -128.
        begin
            logic [319:0] f2, t2;
            for (int i = 0; i < 40; i++) begin
                f2[8*i +: 8] = (i < 20) ? 8'h7f : 8'h80;
                t2[8*i +: 8] = (i < 20) ? 8'h80 : 8'h7f;
            end
            apply(f2, t2);
            chk("R2 signed extremes", int'(sc_a), 20);
        end

        // R10: changing thr_i alone must not move the fixed-threshold instance.
        begin
            logic [4:0] p0, n0;
            @(negedge clk);
            feat = build_feat(7, 5, FIX_THR);
            thr  = '0;
            #2;
            p0 = pos_b; n0 = neg_b;
            thr = {10{32'hffff_ffff}};
            #2;
            chk("R10 thr_i ignored pos", int'(pos_b), int'(p0));
            chk("R10 thr_i ignored neg", int'(neg_b), int'(n0));
        end

        // Constrained random, half of it near the thresholds.
        for (int n = 0; n < 300; n++) begin
            logic [319:0] f, t;
            for (int i = 0; i < 40; i++) begin
                t[8*i +: 8] = 8'($urandom);
                if (n % 2 == 0) f[8*i +: 8] = 8'($urandom);
                else            f[8*i +: 8] = t[8*i +: 8] + 8'($urandom_range(0, 2)) - 8'd1;
            end
            apply(f, t);
        end

        // R9: reset in mid-run clears the registered detect.
        apply(build_feat(20, 0, FIX_THR), FIX_THR);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R9 mid-run reset", int'(det_b), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R8 after reset release", int'(det_b), 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule